// File: doc/BRIEF.md
# Segment Translation and Miss Reporting Front End

This block sits at the head of a 32-bit segmented address translation path. For each request it decides how the effective address is mapped. If relocation is disabled for the access kind, the address passes through untouched with all permissions granted. Otherwise a block-translation hit, reported from outside, wins. Failing that, the segment register chosen by the top address nibble supplies a virtual segment ID, a no-execute flag and two protection-key bits. The block derives the access key, a primary hash and the compare word a page-table entry must carry.

The outcome of the downstream TLB lookup (hit, miss or protection fault) is presented with the request. The block turns it into an exception code and an error word. It also loads the miss-address, compare-word, page-group-address and data-fault status registers that the miss and fault handlers read. Page-table memory is never fetched here: the block only produces the two page-group addresses a software or hardware walker would search. Every output is registered and appears one clock after the request.

Top module: `mmu_seg_front`

## Requirements
- R1: A synchronous active-high reset clears every output to zero. `rsp_valid` equals `req_valid` of the previous cycle, and the response fields belong to that request. `req_kind` is coded as follows: bit 1 set means instruction fetch, 2'b00 means data load and 2'b01 means data store. `tlb_res` is coded as follows: 2'b00 means hit, 2'b01 means miss, and bit 1 set means protection fault.
- R2: When the relocate bit for the access kind is clear (`msr_ir` for fetches, `msr_dr` for loads and stores), the response carries exception code 0, error 0, `rsp_pa` equal to the effective address and `rsp_prot` 3'b111, whatever the block and TLB inputs say.
- R3: With relocation on and `bat_hit` set, the response is code 0 with `bat_pa` and `bat_prot`. No status register changes, even if the segment is no-execute or the TLB reports a miss.
- R4: The segment word is laid out as Ks at bit 26, Kp at bit 25, no-execute at bit 24 and VSID in bits 23..0. It is selected by effective-address bits 31..28. The key is Kp when `msr_pr` is 1 and Ks otherwise, and it appears at error bit 19 of every miss.
- R5: The compare word is 0 at bit 31, the VSID in bits 30..7, 0 at bit 6 and effective-address bits 27..22 in bits 5..0. A miss loads it, with bit 31 set, into `icmp` for fetches and into `dcmp` for data.
- R6: A relocated fetch without a block hit from a no-execute segment gives code 4 with error 0x10000000, whatever the TLB result.
- R7: A fetch miss gives code 1 and error bit 18 plus the key. It loads `imiss` with the effective address. `imiss` and `icmp` change only on fetch misses.
- R8: A load miss gives code 2 with only the key bit in the error word. A store miss gives code 3 with error bit 16 plus the key. Both load `dmiss` with the address. `dmiss` and `dcmp` change only on data misses.
- R9: On any miss, the hash is the VSID XOR address bits 27..12. The table mask is `tbl_mask` placed above ten ones. `hash1` becomes `tbl_base`<<16 plus ((hash AND mask)<<6), and `hash2` is formed the same way from the inverted hash.
- R10: A TLB protection fault on a fetch gives code 4 with error 0x08000000. On data it gives code 5 with error 0 and loads `dar` with the address. `dsisr` is loaded with 0x0A000000 for a store or 0x08000000 for a load. `dar` and `dsisr` change on nothing else.
- R11: A relocated TLB hit without a block hit gives code 0 with `tlb_pa` and `tlb_prot`. On any exception `rsp_pa` and `rsp_prot` are 0.
- R12: A segment-register write takes effect for requests in later cycles. A request in the same cycle as a write to its own segment uses the old contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sr_we | input | 1 | Segment register write enable |
| sr_idx | input | 4 | Segment register written |
| sr_wdata | input | 27 | Segment word: Ks, Kp, no-execute, VSID |
| tbl_base | input | 16 | Upper half of page table base address |
| tbl_mask | input | 9 | Page table size mask, upper hash bits |
| req_valid | input | 1 | Translation request present |
| req_ea | input | 32 | Effective address |
| req_kind | input | 2 | Access kind (fetch, load, store) |
| msr_pr | input | 1 | User (problem) state |
| msr_ir | input | 1 | Fetch relocation enable |
| msr_dr | input | 1 | Data relocation enable |
| bat_hit | input | 1 | Block translation matched with access allowed |
| bat_pa | input | 32 | Block translation physical address |
| bat_prot | input | 3 | Block translation permissions |
| tlb_res | input | 2 | TLB lookup outcome |
| tlb_pa | input | 32 | TLB physical address |
| tlb_prot | input | 3 | TLB permissions |
| rsp_valid | output | 1 | Response present |
| rsp_exc | output | 3 | Exception code (0 none) |
| rsp_err | output | 32 | Error word |
| rsp_pa | output | 32 | Physical address |
| rsp_prot | output | 3 | Granted permissions |
| imiss | output | 32 | Last instruction miss address |
| icmp | output | 32 | Last instruction miss compare word |
| dmiss | output | 32 | Last data miss address |
| dcmp | output | 32 | Last data miss compare word |
| hash1 | output | 32 | Primary page group address |
| hash2 | output | 32 | Secondary page group address |
| dar | output | 32 | Data fault address |
| dsisr | output | 32 | Data fault status |

## Verification
A segment-register write and a translation that indexes the same segment can land in the same clock edge. The bench does this on purpose: it writes a new VSID and key into a segment while a missing load through that segment is presented. It then judges the resulting compare word, key bit and page-group addresses against the old contents, and checks that the following request sees the new ones. The random phase keeps writes and requests overlapping, so the collision also occurs with mixed priorities. These include block hits that must suppress the miss registers, and no-execute fetches that must override a TLB miss.

// File: rtl/mmu_seg_pkg.sv
package mmu_seg_pkg;
  localparam int XLEN     = 32;
  localparam int SEG_CNT  = 16;
  localparam int VSID_W   = 24;
  localparam int SEGW_W   = VSID_W + 3;
  localparam int PG_LSB   = 12;
  localparam int PG_IDX_W = 16;
  localparam int API_W    = 6;

  typedef struct packed {
    logic              ks;
    logic              kp;
    logic              nx;
    logic [VSID_W-1:0] vsid;
  } seg_word_t;

  typedef enum logic [2:0] {
    EXC_NONE   = 3'd0,
    EXC_IMISS  = 3'd1,
    EXC_DLMISS = 3'd2,
    EXC_DSMISS = 3'd3,
    EXC_ISI    = 3'd4,
    EXC_DSI    = 3'd5
  } exc_t;

  typedef enum logic [1:0] {
    PA_NONE = 2'd0,
    PA_EA   = 2'd1,
    PA_BAT  = 2'd2,
    PA_TLB  = 2'd3
  } pa_src_t;

  localparam logic [XLEN-1:0] ERR_NOEXEC   = 32'h1000_0000;
  localparam logic [XLEN-1:0] ERR_IPROT    = 32'h0800_0000;
  localparam logic [XLEN-1:0] DSISR_STORE  = 32'h0A00_0000;
  localparam logic [XLEN-1:0] DSISR_LOAD   = 32'h0800_0000;
  localparam logic [XLEN-1:0] MISS_FLAG    = 32'h8000_0000;
  localparam int              ERR_KEY_BIT  = 19;
  localparam int              ERR_IMISS_BIT = 18;
  localparam int              ERR_SMISS_BIT = 16;
endpackage

// File: rtl/mmu_seg_regs.sv
module mmu_seg_regs
  import mmu_seg_pkg::*;
#(
  parameter int ENTRIES = SEG_CNT,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  seg_word_t     wdata,
  input  logic [IW-1:0] ridx,
  output seg_word_t     rdata
);
  seg_word_t mem [ENTRIES];

  // Small register file; the read is asynchronous so a same-cycle write
  // is seen only by the following request.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/mmu_seg_hash.sv
module mmu_seg_hash
  import mmu_seg_pkg::*;
(
  input  seg_word_t             seg,
  input  logic [PG_IDX_W-1:0]   pg_idx,
  input  logic                  user_mode,
  output logic                  key,
  output logic                  noexec,
  output logic [VSID_W-1:0]     hash,
  output logic [XLEN-1:0]       ptem
);
  localparam int PAD_W = VSID_W - PG_IDX_W;

  assign key    = user_mode ? seg.kp : seg.ks;
  assign noexec = seg.nx;
  assign hash   = seg.vsid ^ {{PAD_W{1'b0}}, pg_idx};
  assign ptem   = {1'b0, seg.vsid, 1'b0, pg_idx[PG_IDX_W-1 -: API_W]};
endmodule

// File: rtl/mmu_pteg_addr.sv
module mmu_pteg_addr
  import mmu_seg_pkg::*;
#(
  parameter int HASH_W     = 19,
  parameter int MASK_W     = 9,
  parameter int BASE_W     = 16,
  parameter int PTEG_SHIFT = 6
) (
  input  logic [VSID_W-1:0] hash,
  input  logic [BASE_W-1:0] base_hi,
  input  logic [MASK_W-1:0] mask_hi,
  output logic [XLEN-1:0]   grp_pri,
  output logic [XLEN-1:0]   grp_sec
);
  localparam int LO_ONES = HASH_W - MASK_W;
  localparam int HI_ZERO = VSID_W - HASH_W;
  localparam int EXT_W   = XLEN - VSID_W;

  logic [VSID_W-1:0] mask_full;
  logic [XLEN-1:0]   base_full;
  logic [1:0][XLEN-1:0] grp;

  assign mask_full = {{HI_ZERO{1'b0}}, mask_hi, {LO_ONES{1'b1}}};
  assign base_full = {base_hi, {(XLEN-BASE_W){1'b0}}};

  for (genvar g = 0; g < 2; g++) begin : g_grp
    logic [VSID_W-1:0] h_sel;
    assign h_sel  = (g == 0) ? hash : ~hash;
    assign grp[g] = base_full + ({{EXT_W{1'b0}}, h_sel & mask_full} << PTEG_SHIFT);
  end

  assign grp_pri = grp[0];
  assign grp_sec = grp[1];
endmodule

// File: rtl/mmu_fault_class.sv
module mmu_fault_class
  import mmu_seg_pkg::*;
(
  input  logic            reloc_on,
  input  logic            is_fetch,
  input  logic            is_store,
  input  logic            bat_hit,
  input  logic            noexec,
  input  logic            key,
  input  logic [1:0]      tlb_res,
  output exc_t            exc,
  output logic [XLEN-1:0] err,
  output pa_src_t         pa_src
);
  logic [XLEN-1:0] key_bit;
  assign key_bit = {{(XLEN-1){1'b0}}, key} << ERR_KEY_BIT;

  // Priority: real mode, block hit, no-execute, TLB fault, TLB miss, hit.
  always_comb begin
    exc    = EXC_NONE;
    err    = '0;
    pa_src = PA_NONE;
    if (!reloc_on) begin
      pa_src = PA_EA;
    end else if (bat_hit) begin
      pa_src = PA_BAT;
    end else if (is_fetch && noexec) begin
      exc = EXC_ISI;
      err = ERR_NOEXEC;
    end else if (tlb_res[1]) begin
      if (is_fetch) begin
        exc = EXC_ISI;
        err = ERR_IPROT;
      end else begin
        exc = EXC_DSI;
      end
    end else if (tlb_res[0]) begin
      if (is_fetch) begin
        exc = EXC_IMISS;
        err = key_bit | (XLEN'(1) << ERR_IMISS_BIT);
      end else if (is_store) begin
        exc = EXC_DSMISS;
        err = key_bit | (XLEN'(1) << ERR_SMISS_BIT);
      end else begin
        exc = EXC_DLMISS;
        err = key_bit;
      end
    end else begin
      pa_src = PA_TLB;
    end
  end
endmodule

// File: rtl/mmu_seg_front.sv
module mmu_seg_front
  import mmu_seg_pkg::*;
#(
  parameter int HASH_W     = 19,
  parameter int MASK_W     = 9,
  parameter int BASE_W     = 16,
  parameter int PTEG_SHIFT = 6,
  localparam int SEG_IW    = $clog2(SEG_CNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sr_we,
  input  logic [SEG_IW-1:0] sr_idx,
  input  logic [SEGW_W-1:0] sr_wdata,
  input  logic [BASE_W-1:0] tbl_base,
  input  logic [MASK_W-1:0] tbl_mask,
  input  logic              req_valid,
  input  logic [XLEN-1:0]   req_ea,
  input  logic [1:0]        req_kind,
  input  logic              msr_pr,
  input  logic              msr_ir,
  input  logic              msr_dr,
  input  logic              bat_hit,
  input  logic [XLEN-1:0]   bat_pa,
  input  logic [2:0]        bat_prot,
  input  logic [1:0]        tlb_res,
  input  logic [XLEN-1:0]   tlb_pa,
  input  logic [2:0]        tlb_prot,
  output logic              rsp_valid,
  output logic [2:0]        rsp_exc,
  output logic [XLEN-1:0]   rsp_err,
  output logic [XLEN-1:0]   rsp_pa,
  output logic [2:0]        rsp_prot,
  output logic [XLEN-1:0]   imiss,
  output logic [XLEN-1:0]   icmp,
  output logic [XLEN-1:0]   dmiss,
  output logic [XLEN-1:0]   dcmp,
  output logic [XLEN-1:0]   hash1,
  output logic [XLEN-1:0]   hash2,
  output logic [XLEN-1:0]   dar,
  output logic [XLEN-1:0]   dsisr
);
  logic              is_fetch, is_store, reloc_on;
  seg_word_t         seg_rd;
  logic              key, noexec;
  logic [VSID_W-1:0] hash;
  logic [XLEN-1:0]   ptem, grp_pri, grp_sec, err;
  exc_t              exc;
  pa_src_t           pa_src;

  assign is_fetch = req_kind[1];
  assign is_store = ~req_kind[1] & req_kind[0];
  assign reloc_on = is_fetch ? msr_ir : msr_dr;

  mmu_seg_regs #(.ENTRIES(SEG_CNT)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (sr_we),
    .widx  (sr_idx),
    .wdata (seg_word_t'(sr_wdata)),
    .ridx  (req_ea[XLEN-1 -: SEG_IW]),
    .rdata (seg_rd)
  );

  mmu_seg_hash u_hash (
    .seg       (seg_rd),
    .pg_idx    (req_ea[PG_LSB +: PG_IDX_W]),
    .user_mode (msr_pr),
    .key       (key),
    .noexec    (noexec),
    .hash      (hash),
    .ptem      (ptem)
  );

  mmu_pteg_addr #(
    .HASH_W(HASH_W), .MASK_W(MASK_W), .BASE_W(BASE_W), .PTEG_SHIFT(PTEG_SHIFT)
  ) u_pteg (
    .hash    (hash),
    .base_hi (tbl_base),
    .mask_hi (tbl_mask),
    .grp_pri (grp_pri),
    .grp_sec (grp_sec)
  );

  mmu_fault_class u_class (
    .reloc_on (reloc_on),
    .is_fetch (is_fetch),
    .is_store (is_store),
    .bat_hit  (bat_hit),
    .noexec   (noexec),
    .key      (key),
    .tlb_res  (tlb_res),
    .exc      (exc),
    .err      (err),
    .pa_src   (pa_src)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_exc   <= '0;
      rsp_err   <= '0;
      rsp_pa    <= '0;
      rsp_prot  <= '0;
      imiss     <= '0;
      icmp      <= '0;
      dmiss     <= '0;
      dcmp      <= '0;
      hash1     <= '0;
      hash2     <= '0;
      dar       <= '0;
      dsisr     <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_exc <= exc;
        rsp_err <= err;
        unique case (pa_src)
          PA_EA:   begin rsp_pa <= req_ea; rsp_prot <= 3'b111;   end
          PA_BAT:  begin rsp_pa <= bat_pa; rsp_prot <= bat_prot; end
          PA_TLB:  begin rsp_pa <= tlb_pa; rsp_prot <= tlb_prot; end
          default: begin rsp_pa <= '0;     rsp_prot <= '0;       end
        endcase
        unique case (exc)
          EXC_IMISS: begin
            imiss <= req_ea;
            icmp  <= ptem | MISS_FLAG;
            hash1 <= grp_pri;
            hash2 <= grp_sec;
          end
          EXC_DLMISS, EXC_DSMISS: begin
            dmiss <= req_ea;
            dcmp  <= ptem | MISS_FLAG;
            hash1 <= grp_pri;
            hash2 <= grp_sec;
          end
          EXC_DSI: begin
            dar   <= req_ea;
            dsisr <= is_store ? DSISR_STORE : DSISR_LOAD;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mmu_seg_front_chk.sv
module mmu_seg_front_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic [31:0] req_ea,
  input logic [1:0]  req_kind,
  input logic        msr_ir,
  input logic        msr_dr,
  input logic        bat_hit,
  input logic [31:0] bat_pa,
  input logic        rsp_valid,
  input logic [2:0]  rsp_exc,
  input logic [31:0] rsp_err,
  input logic [31:0] rsp_pa,
  input logic [2:0]  rsp_prot,
  input logic [31:0] imiss,
  input logic [31:0] icmp,
  input logic [31:0] dmiss,
  input logic [31:0] dar
);
  logic reloc;
  assign reloc = req_kind[1] ? msr_ir : msr_dr;

  a_r1_rsp_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  a_r1_rsp_idle: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  a_r2_bypass: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !reloc) |=>
      (rsp_exc == 3'd0 && rsp_pa == $past(req_ea) && rsp_prot == 3'b111));

  a_r3_block_first: assert property (@(posedge clk) disable iff (rst)
    (req_valid && reloc && bat_hit) |=>
      (rsp_exc == 3'd0 && rsp_pa == $past(bat_pa) && $stable(imiss) && $stable(dmiss)));

  a_r7_imiss_load: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_exc == 3'd1) |-> (imiss == $past(req_ea) && icmp[31]));

  a_r8_dmiss_hold: assert property (@(posedge clk) disable iff (rst)
    !(rsp_valid && (rsp_exc == 3'd2 || rsp_exc == 3'd3)) |-> $stable(dmiss));

  a_r10_dar_load: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_exc == 3'd5) |-> (dar == $past(req_ea)));

  a_r11_clean_ok: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_exc == 3'd0) |-> (rsp_err == 32'd0));
endmodule

bind mmu_seg_front mmu_seg_front_chk u_chk (.*);

// File: tb/mmu_seg_front_tb.sv
module mmu_seg_front_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sr_we = 1'b0;
  logic [3:0]  sr_idx = '0;
  logic [26:0] sr_wdata = '0;
  logic [15:0] tbl_base = '0;
  logic [8:0]  tbl_mask = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_ea = '0;
  logic [1:0]  req_kind = '0;
  logic        msr_pr = 1'b0, msr_ir = 1'b0, msr_dr = 1'b0;
  logic        bat_hit = 1'b0;
  logic [31:0] bat_pa = '0;
  logic [2:0]  bat_prot = '0;
  logic [1:0]  tlb_res = '0;
  logic [31:0] tlb_pa = '0;
  logic [2:0]  tlb_prot = '0;
  logic        rsp_valid;
  logic [2:0]  rsp_exc, rsp_prot;
  logic [31:0] rsp_err, rsp_pa, imiss, icmp, dmiss, dcmp, hash1, hash2, dar, dsisr;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmu_seg_front u_dut (.*);

  // ---------------- reference model ----------------
  logic [26:0] sr_m [16];
  logic        e_valid = 0;
  logic [2:0]  e_exc = 0, e_prot = 0;
  logic [31:0] e_err = 0, e_pa = 0, e_imiss = 0, e_icmp = 0, e_dmiss = 0, e_dcmp = 0;
  logic [31:0] e_h1 = 0, e_h2 = 0, e_dar = 0, e_dsisr = 0;
  string       e_tag = "R1";
  bit          e_miss = 0;

  int checks = 0, errors = 0;
  bit armed = 0, done = 0;

  task automatic model_step();
    bit fetch, store, reloc, ks, kp, nx, key;
    logic [26:0] w;
    logic [31:0] vsid, pg, h, msk, base, cw, h1, h2;
    fetch = req_kind[1];
    store = !fetch && req_kind[0];
    reloc = fetch ? msr_ir : msr_dr;
    w = sr_m[req_ea[31:28]];
    ks = w[26]; kp = w[25]; nx = w[24];
    vsid = {8'h0, w[23:0]};
    key = msr_pr ? kp : ks;
    pg = {16'h0, req_ea[27:12]};
    h = vsid ^ pg;
    cw = (vsid << 7) | (pg >> 10);
    msk = ({23'h0, tbl_mask} << 10) | 32'h3FF;
    base = {tbl_base, 16'h0};
    h1 = base + ((h & msk) << 6);
    h2 = base + ((~h & msk) << 6);
    e_pa = 0; e_prot = 0; e_exc = 0; e_err = 0; e_miss = 0;
    if (!reloc) begin
      e_pa = req_ea; e_prot = 3'b111; e_tag = "R2";
    end else if (bat_hit) begin
      e_pa = bat_pa; e_prot = bat_prot; e_tag = "R3";
    end else if (fetch && nx) begin
      e_exc = 4; e_err = 32'h1000_0000; e_tag = "R6";
    end else if (tlb_res >= 2) begin
      e_tag = "R10";
      if (fetch) begin e_exc = 4; e_err = 32'h0800_0000; end
      else begin
        e_exc = 5; e_dar = req_ea;
        e_dsisr = store ? 32'h0A00_0000 : 32'h0800_0000;
      end
    end else if (tlb_res == 1) begin
      e_miss = 1;
      e_h1 = h1; e_h2 = h2;
      if (fetch) begin
        e_exc = 1; e_err = (32'(key) << 19) | (1 << 18);
        e_imiss = req_ea; e_icmp = cw | 32'h8000_0000; e_tag = "R7";
      end else begin
        e_exc = store ? 3 : 2;
        e_err = (32'(key) << 19) | (store ? (1 << 16) : 0);
        e_dmiss = req_ea; e_dcmp = cw | 32'h8000_0000; e_tag = "R8";
      end
    end else begin
      e_pa = tlb_pa; e_prot = tlb_prot; e_tag = "R11";
    end
    if (sr_we && sr_idx == req_ea[31:28]) e_tag = "R12";
  endtask

  always @(posedge clk) begin
    if (rst) begin
      e_valid = 0; e_exc = 0; e_err = 0; e_pa = 0; e_prot = 0;
      e_imiss = 0; e_icmp = 0; e_dmiss = 0; e_dcmp = 0;
      e_h1 = 0; e_h2 = 0; e_dar = 0; e_dsisr = 0; e_tag = "R1"; e_miss = 0;
      for (int i = 0; i < 16; i++) sr_m[i] = '0;
    end else begin
      e_valid = req_valid;
      if (req_valid) model_step();
      if (sr_we) sr_m[sr_idx] = sr_wdata;
    end
  end

  // ---------------- comparison every clock ----------------
  task automatic chk(string tag, string name, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, name, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (armed && !done) begin
      chk("R1", "rsp_valid", {31'h0, rsp_valid}, {31'h0, e_valid});
      if (e_valid) begin
        chk(e_tag, "rsp_exc", {29'h0, rsp_exc}, {29'h0, e_exc});
        chk(e_miss ? "R4" : e_tag, "rsp_err", rsp_err, e_err);
        chk(e_tag, "rsp_pa", rsp_pa, e_pa);
        chk(e_tag, "rsp_prot", {29'h0, rsp_prot}, {29'h0, e_prot});
      end
      chk("R7", "imiss", imiss, e_imiss);
      chk("R5", "icmp", icmp, e_icmp);
      chk("R8", "dmiss", dmiss, e_dmiss);
      chk("R5", "dcmp", dcmp, e_dcmp);
      chk("R9", "hash1", hash1, e_h1);
      chk("R9", "hash2", hash2, e_h2);
      chk("R10", "dar", dar, e_dar);
      chk("R10", "dsisr", dsisr, e_dsisr);
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle();
    req_valid = 0; sr_we = 0;
    @(negedge clk);
  endtask

  task automatic wr_sr(input logic [3:0] idx, input logic [26:0] d);
    sr_we = 1; sr_idx = idx; sr_wdata = d;
    @(negedge clk);
    sr_we = 0;
  endtask

  task automatic req(input logic [31:0] ea, input logic [1:0] kind, input bit pr,
                     input bit ir, input bit dr, input bit bh, input logic [1:0] tr);
    req_valid = 1; req_ea = ea; req_kind = kind;
    msr_pr = pr; msr_ir = ir; msr_dr = dr;
    bat_hit = bh; bat_pa = 32'hB000_0000 | ea[19:0]; bat_prot = 3'b101;
    tlb_res = tr; tlb_pa = 32'h7000_0000 | ea[11:0]; tlb_prot = 3'b011;
    @(negedge clk);
    req_valid = 0;
  endtask

  function automatic string summary_line();
    return $sformatf("Simulation finished: %0d checks, %0d errors", checks, errors);
  endfunction

  initial begin
    tbl_base = 16'h0010; tbl_mask = 9'h003;
    repeat (2) @(posedge clk);
    @(negedge clk);
    armed = 1;                 // R1: reset values compared here
    @(negedge clk);
    rst = 0;
    // segments: 3 user key 1, 7 no-execute, 5 plain
    wr_sr(4'd3, {1'b0, 1'b1, 1'b0, 24'h012345});
    wr_sr(4'd7, {1'b1, 1'b0, 1'b1, 24'h0ABCDE});
    wr_sr(4'd5, {1'b0, 1'b0, 1'b0, 24'h000111});
    idle();
    // R2: bypass, fetch with IR off and load with DR off
    req(32'h3456_7ABC, 2'd2, 0, 0, 1, 1, 2'd1);
    req(32'h3456_7ABC, 2'd0, 0, 1, 0, 0, 2'd2);
    // R3: block hit wins over TLB miss and no-execute
    req(32'h7000_1000, 2'd2, 0, 1, 1, 1, 2'd1);
    // R11: TLB hit
    req(32'h3000_2004, 2'd1, 0, 1, 1, 0, 2'd0);
    // R6: no-execute beats TLB miss
    req(32'h7123_4000, 2'd3, 0, 1, 1, 0, 2'd1);
    // R7, R4, R5, R9: fetch miss, user key from Kp
    req(32'h3ABC_D000, 2'd2, 1, 1, 1, 0, 2'd1);
    // R8: load miss supervisor key 0, store miss user key 1
    req(32'h3FFF_F010, 2'd0, 0, 1, 1, 0, 2'd1);
    req(32'h3004_5678, 2'd1, 1, 1, 1, 0, 2'd1);
    // R9: different table mask
    tbl_mask = 9'h1FF; tbl_base = 16'hFF00;
    req(32'h5C00_0000, 2'd0, 0, 1, 1, 0, 2'd1);
    // R10: protection faults fetch, load, store
    req(32'h5000_0040, 2'd2, 0, 1, 1, 0, 2'd2);
    req(32'h5000_0080, 2'd0, 0, 1, 1, 0, 2'd3);
    req(32'h5000_00C0, 2'd1, 0, 1, 1, 0, 2'd2);
    // R12: write segment 5 in the same cycle as a missing load through it
    sr_we = 1; sr_idx = 4'd5; sr_wdata = {1'b1, 1'b0, 1'b0, 24'h0F0F0F};
    req(32'h5123_4000, 2'd0, 0, 1, 1, 0, 2'd1);
    sr_we = 0;
    req(32'h5123_4000, 2'd0, 0, 1, 1, 0, 2'd1);
    idle();
    // random phase with overlapping writes
    for (int i = 0; i < 400; i++) begin
      sr_we = ($urandom_range(0, 3) == 0);
      sr_idx = 4'($urandom_range(0, 15));
      sr_wdata = 27'($urandom());
      if ($urandom_range(0, 7) == 0) tbl_mask = 9'($urandom());
      if ($urandom_range(0, 7) == 0) tbl_base = 16'($urandom());
      if ($urandom_range(0, 4) == 0) idle();
      else req($urandom(), 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
               ($urandom_range(0, 5) != 0), ($urandom_range(0, 5) != 0),
               ($urandom_range(0, 4) == 0), 2'($urandom_range(0, 3)));
    end
    idle();
    idle();
    if (!done) begin
      done = 1;
      $display("%s", summary_line());
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("%s", summary_line());
      $finish;
    end
  end
endmodule